// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory

This block is a small synchronous memory for 8-bit words that guards each stored word with four Hamming check bits. On a write, the data is expanded into a 12-bit codeword. Check bits sit at the codeword positions whose index is a power of two, and data bits fill the remaining positions. The whole codeword is stored.

On a read, the stored data bits are pulled out and their check bits are computed again. These fresh check bits are XORed with the stored ones to give a 4-bit syndrome. A nonzero syndrome in the range 1 to 12 names the one codeword position that flipped. The block inverts that position and returns the repaired data together with a "corrected" flag. A syndrome of 13 to 15 cannot come from a single flip, so it is reported as uncorrectable and the data is passed through without repair.

Results arrive one clock after the read request and are qualified by a valid output. A test-only mask input is XORed into the codeword as it is written, so that a test can plant bit errors deliberately. The number of check bits follows from the rule that 2^C - 1 must be at least the data width plus C.

Top module: `sec_ram`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, the codeword built from `wr_data`, XORed bitwise with `inj_mask`, is stored at `wr_addr`. With an all-zero mask, a later read of that address returns `wr_data` with a zero syndrome.
- R2: Codeword bit p-1 holds position p. Check bits c1 to c4 sit at positions 1, 2, 4 and 8. Data bits `wr_data[0]` to `wr_data[7]` sit, in that order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. The check bits are: c1 = d0^d1^d3^d4^d6, c2 = d0^d2^d3^d5^d6, c3 = d1^d2^d3^d7, c4 = d4^d5^d6^d7, where dN is `wr_data[N]`.
- R3: `rd_valid` is high exactly in the cycle after a rising edge that samples `rd_en` high. `rd_data`, the flags and `rd_syndrome` for that read are presented in that same cycle. Back-to-back reads produce back-to-back results.
- R4: A read of an intact codeword gives a syndrome of 0, returns the stored data, and keeps both `rd_corrected` and `rd_uncorrectable` low.
- R5: If a single data position p is flipped in storage, the read gives `rd_syndrome` = p, returns the original data, and raises `rd_corrected` with `rd_uncorrectable` low.
- R6: If a single check-bit position (1, 2, 4 or 8) is flipped, the read gives that position as the syndrome, returns the data unchanged, and still raises `rd_corrected`.
- R7: A syndrome of 13, 14 or 15 raises `rd_uncorrectable`, keeps `rd_corrected` low, and returns the stored data bits without any repair.
- R8: While `rst_n` is low and after its release, `rd_valid`, `rd_corrected`, `rd_uncorrectable`, `rd_syndrome` and `rd_data` are zero until the first read result.
- R9: A read and a write to the same address at the same clock edge return the contents from before that write. The new contents are seen by later reads.
- R10: In a cycle where `rd_valid` is low, `rd_corrected` and `rd_uncorrectable` are low and `rd_syndrome` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read result registers |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 8 | Data to store |
| inj_mask | input | 12 | Test mask XORed into the codeword on write (zero in normal use) |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_valid | output | 1 | Read result is valid this cycle |
| rd_data | output | 8 | Corrected read data |
| rd_corrected | output | 1 | A single-position error was located (and repaired if it hit data) |
| rd_uncorrectable | output | 1 | Syndrome lies outside the codeword positions |
| rd_syndrome | output | 4 | Syndrome of the read codeword |

## Verification
The storage itself can only be corrupted through the write-time mask. The bench therefore walks a one-hot mask across all twelve positions to cover every data and check-bit repair. The hardest outcome to reach is a syndrome above 12, which a single flip never produces. The bench plants two flips whose position indices XOR to 13, 14 and 15 (12 with 1, 2 or 3) and compares the unrepaired data against its own position-XOR model of the codeword.

// File: rtl/sec_ram_pkg.sv
package sec_ram_pkg;

  localparam int DATA_W = 8;

  // smallest C with 2^C - 1 >= DATA_W + C
  function automatic int chk_count(input int m);
    int c;
    c = 1;
    while (((1 << c) - 1) < (m + c)) c++;
    return c;
  endfunction

  localparam int CHK_W = chk_count(DATA_W);
  localparam int CW_W  = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [CW_W-1:0]   cw_t;

  function automatic bit is_chk_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // scatter data bits over the non power-of-two positions, checks left zero
  function automatic cw_t place_data(input data_t d);
    cw_t cw;
    int  j;
    cw = '0;
    j  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        cw[p-1] = d[j];
        j++;
      end
    end
    return cw;
  endfunction

  function automatic data_t pull_data(input cw_t cw);
    data_t d;
    int    j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        d[j] = cw[p-1];
        j++;
      end
    end
    return d;
  endfunction

  // check bit k is the parity of every data position whose index has bit k set
  function automatic chk_t calc_chk(input data_t d);
    cw_t  cw;
    chk_t c;
    cw = place_data(d);
    c  = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> k) & 1) == 1) c[k] = c[k] ^ cw[p-1];
      end
    end
    return c;
  endfunction

  function automatic chk_t pull_chk(input cw_t cw);
    chk_t c;
    for (int k = 0; k < CHK_W; k++) c[k] = cw[(1 << k) - 1];
    return c;
  endfunction

  function automatic cw_t encode(input data_t d);
    cw_t  cw;
    chk_t c;
    cw = place_data(d);
    c  = calc_chk(d);
    for (int k = 0; k < CHK_W; k++) cw[(1 << k) - 1] = c[k];
    return cw;
  endfunction

endpackage

// File: rtl/sec_encoder.sv
module sec_encoder
  import sec_ram_pkg::*;
(
  input  data_t data,
  input  cw_t   inj_mask,
  output cw_t   cw
);

  cw_t clean_cw;

  assign clean_cw = encode(data);
  assign cw       = clean_cw ^ inj_mask;

endmodule

// File: rtl/sec_store.sv
module sec_store
  import sec_ram_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cw_t               wr_cw,
  input  logic [ADDR_W-1:0] rd_addr,
  output cw_t               rd_cw
);

  cw_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_cw;
  end

  // combinational fetch; the top registers the decoded result, so a
  // same-edge write is not yet visible (read-before-write)
  assign rd_cw = mem[rd_addr];

endmodule

// File: rtl/sec_decoder.sv
module sec_decoder
  import sec_ram_pkg::*;
(
  input  cw_t   cw,
  output data_t data,
  output chk_t  syndrome,
  output logic  corrected,
  output logic  uncorrectable
);

  data_t raw_data;
  chk_t  stored_chk;
  chk_t  fresh_chk;
  cw_t   flip_mask;
  cw_t   fixed_cw;
  logic  in_range;

  assign raw_data   = pull_data(cw);
  assign stored_chk = pull_chk(cw);
  assign fresh_chk  = calc_chk(raw_data);
  assign syndrome   = stored_chk ^ fresh_chk;

  for (genvar p = 1; p <= CW_W; p++) begin : g_flip
    assign flip_mask[p-1] = (syndrome == CHK_W'(p));
  end

  assign in_range      = |flip_mask;
  assign corrected     = in_range;
  assign uncorrectable = (syndrome != '0) && !in_range;
  assign fixed_cw      = cw ^ flip_mask;
  assign data          = pull_data(fixed_cw);

endmodule

// File: rtl/sec_ram.sv
module sec_ram
  import sec_ram_pkg::*;
#(
  parameter  int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [11:0]       inj_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_corrected,
  output logic              rd_uncorrectable,
  output logic [3:0]        rd_syndrome
);

  cw_t   wr_cw;
  cw_t   fetched_cw;
  data_t dec_data;
  chk_t  dec_syndrome;
  logic  dec_corrected;
  logic  dec_uncorrectable;

  sec_encoder u_enc (
    .data     (wr_data),
    .inj_mask (inj_mask),
    .cw       (wr_cw)
  );

  sec_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_cw   (wr_cw),
    .rd_addr (rd_addr),
    .rd_cw   (fetched_cw)
  );

  sec_decoder u_dec (
    .cw            (fetched_cw),
    .data          (dec_data),
    .syndrome      (dec_syndrome),
    .corrected     (dec_corrected),
    .uncorrectable (dec_uncorrectable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid         <= 1'b0;
      rd_data          <= '0;
      rd_corrected     <= 1'b0;
      rd_uncorrectable <= 1'b0;
      rd_syndrome      <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data          <= dec_data;
        rd_corrected     <= dec_corrected;
        rd_uncorrectable <= dec_uncorrectable;
        rd_syndrome      <= dec_syndrome;
      end else begin
        rd_corrected     <= 1'b0;
        rd_uncorrectable <= 1'b0;
        rd_syndrome      <= '0;
      end
    end
  end

endmodule

// File: rtl/sec_ram_chk.sv
module sec_ram_chk
  import sec_ram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic [11:0] inj_mask,
  input logic [11:0] wr_cw,
  input logic       rd_valid,
  input logic       rd_corrected,
  input logic       rd_uncorrectable,
  input logic [3:0] rd_syndrome
);

  // syndrome of a codeword as the XOR of the indices of its set positions
  logic [3:0] wr_cw_syn;
  always_comb begin
    wr_cw_syn = '0;
    for (int p = 1; p <= 12; p++) begin
      if (wr_cw[p-1]) wr_cw_syn = wr_cw_syn ^ 4'(p);
    end
  end

  assert_clean_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inj_mask == 12'd0) |-> (wr_cw_syn == 4'd0));

  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_clean_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_syndrome == 4'd0) |-> (!rd_corrected && !rd_uncorrectable));

  assert_in_range_corrects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_syndrome != 4'd0 && rd_syndrome <= 4'd12) |-> (rd_corrected && !rd_uncorrectable));

  assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_syndrome > 4'd12) |-> (rd_uncorrectable && !rd_corrected));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!rd_corrected && !rd_uncorrectable && rd_syndrome == 4'd0));

endmodule

bind sec_ram sec_ram_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rd_en            (rd_en),
  .wr_en            (wr_en),
  .inj_mask         (inj_mask),
  .wr_cw            (wr_cw),
  .rd_valid         (rd_valid),
  .rd_corrected     (rd_corrected),
  .rd_uncorrectable (rd_uncorrectable),
  .rd_syndrome      (rd_syndrome)
);

// File: tb/sim_sec_ram.sv
`timescale 1ns/1ps
module sim_sec_ram;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [11:0]       inj_mask = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_valid;
  logic [7:0]        rd_data;
  logic              rd_corrected;
  logic              rd_uncorrectable;
  logic [3:0]        rd_syndrome;

  always #2 clk = ~clk;  // 250 MHz

  sec_ram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .inj_mask(inj_mask), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrected(rd_corrected),
    .rd_uncorrectable(rd_uncorrectable), .rd_syndrome(rd_syndrome)
  );

  typedef struct {
    logic [7:0] d;
    logic       c;
    logic       u;
    logic [3:0] s;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  logic [11:0] model [DEPTH];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          monitor_on = 1'b0;
  bit          done = 1'b0;

  // codeword by explicit equations (bit p-1 = position p)
  function automatic logic [11:0] ref_encode(input logic [7:0] d);
    logic [11:0] w;
    w[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    w[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    w[2]  = d[0];
    w[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    w[4]  = d[1];
    w[5]  = d[2];
    w[6]  = d[3];
    w[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    w[8]  = d[4];
    w[9]  = d[5];
    w[10] = d[6];
    w[11] = d[7];
    return w;
  endfunction

  function automatic logic [7:0] ref_data(input logic [11:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  function automatic exp_t ref_read(input logic [11:0] w, input string tag);
    exp_t e;
    logic [3:0] s;
    logic [11:0] f;
    s = '0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) s = s ^ 4'(p);
    f = w;
    if (s != 0 && s <= 12) f[s-1] = ~f[s-1];
    e.d = ref_data(f);
    e.c = (s != 0 && s <= 12);
    e.u = (s > 12);
    e.s = s;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input logic [11:0] m);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; inj_mask = m;
    model[a] = ref_encode(d) ^ m;
    @(posedge clk); #1;
    wr_en = 1'b0; inj_mask = '0;
  endtask

  task automatic do_read(input int a, input string tag);
    sb.push_back(ref_read(model[a], tag));
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // R9: read and write same address on one edge
  task automatic do_read_write(input int a, input logic [7:0] d);
    sb.push_back(ref_read(model[a], "R9"));
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; inj_mask = '0;
    model[a] = ref_encode(d);
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monitor_on) begin
      if (rd_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3", "rd_valid with no pending read, actual 1 expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rd_data == e.d && rd_corrected == e.c && rd_uncorrectable == e.u
                && rd_syndrome == e.s, e.tag,
                $sformatf("actual d=%h c=%0b u=%0b s=%0d expected d=%h c=%0b u=%0b s=%0d",
                          rd_data, rd_corrected, rd_uncorrectable, rd_syndrome,
                          e.d, e.c, e.u, e.s));
        end
      end else begin
        check(!rd_corrected && !rd_uncorrectable && rd_syndrome == 0, "R10",
              $sformatf("idle flags actual c=%0b u=%0b s=%0d expected 0 0 0",
                        rd_corrected, rd_uncorrectable, rd_syndrome));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(rd_valid == 0 && rd_corrected == 0 && rd_uncorrectable == 0 &&
          rd_syndrome == 0 && rd_data == 0, "R8",
          $sformatf("in reset actual v=%0b d=%h expected 0 00", rd_valid, rd_data));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 0 && rd_corrected == 0 && rd_uncorrectable == 0 &&
          rd_syndrome == 0 && rd_data == 0, "R8",
          $sformatf("after reset actual v=%0b d=%h expected 0 00", rd_valid, rd_data));
    @(posedge clk); #1;
    monitor_on = 1'b1;

    // R1/R4: clean fill and readback, back-to-back reads (R3)
    for (int a = 0; a < DEPTH; a++) do_write(a, 8'((a * 37 + 5) ^ (a << 4)), 12'd0);
    for (int a = 0; a < DEPTH; a++) do_read(a, "R1");
    do_write(0, 8'h00, 12'd0); do_read(0, "R4");
    do_write(1, 8'hFF, 12'd0); do_read(1, "R4");
    do_write(2, 8'hA5, 12'd0); do_read(2, "R2");

    // R5/R6: one-hot error at every position, two data patterns
    for (int p = 1; p <= 12; p++) begin
      do_write(3, 8'h5C, 12'(1) << (p - 1));
      do_read(3, ((p & (p - 1)) == 0) ? "R6" : "R5");
      @(posedge clk); #1;  // idle cycle between reads (R10)
    end
    for (int p = 1; p <= 12; p++) begin
      do_write(4, 8'h93, 12'(1) << (p - 1));
      do_read(4, ((p & (p - 1)) == 0) ? "R6" : "R2");
    end

    // R7: double flips producing syndromes 13, 14, 15
    do_write(5, 8'h3C, 12'h801); do_read(5, "R7");
    do_write(6, 8'hC3, 12'h802); do_read(6, "R7");
    do_write(7, 8'h7E, 12'h804); do_read(7, "R7");

    // R9: read-during-write returns old contents, then new ones
    do_write(8, 8'h11, 12'd0);
    do_read_write(8, 8'hEE);
    do_read(8, "R9");

    repeat (4) @(posedge clk);
    #1;
    check(sb.size() == 0, "R3",
          $sformatf("pending reads actual %0d expected 0", sb.size()));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule